// File: doc/BRIEF.md
# Indexed Register Window for an Interrupt Redirection Table

This block is a 32-bit memory-mapped register slave. A processor does not address the controller's internal registers directly. It first writes a register number into an 8-bit select register, then reads or writes that register through a single 32-bit data window. Behind the window sit three things: an identification register, a read-only version word computed from the table size, and an arbitration word that always reads as zero. There is also a table of 64-bit redirection entries, and each entry is reached as two 32-bit halves.

The whole table is presented in parallel to downstream dispatch logic. Each time a half is written, the block emits a one-cycle notification that carries the number of the entry that changed. Reads return their data one cycle after the request, marked by a valid pulse. Only the low eight address bits reach the block, and any offset that is neither the select register nor the window is inert.

Top module: `ridx_window`

## Requirements
- R1: Offset 0x00 holds the 8-bit select register. A write stores wdata bits 7:0, a read returns the select value zero-extended, and the register is zero after reset.
- R2: With select value 0, the window accesses the 4-bit ID. A read returns the ID in bits 27:24 with every other bit zero, a write keeps only wdata bits 27:24, and the ID is zero after reset.
- R3: With select value 1, the window reads 0x11 in bits 7:0 and (entry count − 1) in bits 23:16, with all other bits zero. Writes leave it unchanged.
- R4: With select value 2, the window reads zero and writes have no effect.
- R5: For a select value s ≥ 0x10, the window reaches entry (s − 0x10) >> 1. An odd s reaches bits 63:32 and an even s reaches bits 31:0. A write replaces only that half.
- R6: A window access with select 3..0x0F, or with a computed entry index at or beyond the entry count, reads zero and changes no state.
- R7: After reset, every entry equals 0x0000_0000_0001_0000, meaning only the mask bit 16 is set.
- R8: Accesses at offsets other than 0x00 and 0x10 read zero and change no state.
- R9: A read request is answered in the following cycle, with rvalid_o high for that one cycle. rdata_o is zero whenever rvalid_o is low.
- R10: A write that reaches an entry half raises upd_o for exactly the following cycle, with upd_idx_o giving the entry index. No other access raises upd_o.
- R11: ent_tbl_o carries entry i on bits [64*i+63 : 64*i]. It reflects each write from the cycle after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset (low eight address bits) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| rvalid_o | output | 1 | Read data valid |
| ent_tbl_o | output | 64*N_ENT | Whole redirection table |
| upd_o | output | 1 | Entry-updated pulse |
| upd_idx_o | output | IDX_W | Index of the updated entry |

## Verification
The update notification from a half write lands in the same cycle as a read of that same half issued immediately after the write. The bench provokes this with back-to-back write/read pairs, and also with randomized streams that mix select changes, window writes and window reads. In that cycle, the reference model requires two things at once: upd_o and upd_idx_o must report the write, and the read response one cycle later must already carry the new half while the other half stays intact. A second collision is a select write followed directly by a window access. That access must be decoded with the new select value.

// File: rtl/ridx_pkg.sv
package ridx_pkg;
  localparam logic [7:0] OFF_SEL  = 8'h00;
  localparam logic [7:0] OFF_WIN  = 8'h10;
  localparam logic [7:0] SEL_ID   = 8'h00;
  localparam logic [7:0] SEL_VER  = 8'h01;
  localparam logic [7:0] SEL_ARB  = 8'h02;
  localparam logic [7:0] SEL_ENT0 = 8'h10;
  localparam logic [7:0] VER_CODE = 8'h11;
  localparam int unsigned ID_LSB  = 24;
  localparam int unsigned ID_W    = 4;
  localparam int unsigned MASK_BIT = 16;
  localparam logic [63:0] ENT_RST = 64'(1) << MASK_BIT;

  typedef enum logic [2:0] {
    TGT_NONE, TGT_SEL, TGT_ID, TGT_VER, TGT_ARB, TGT_ENT
  } tgt_e;
endpackage

// File: rtl/ridx_decode.sv
module ridx_decode
  import ridx_pkg::*;
#(
  parameter int unsigned N_ENT = 24,
  parameter int unsigned IDX_W = $clog2(N_ENT)
) (
  input  logic [7:0]       off_i,
  input  logic [7:0]       sel_i,
  output tgt_e             tgt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             hi_o
);
  logic [7:0] rel;
  logic [6:0] pair;
  logic       ent_ok;

  assign rel    = sel_i - SEL_ENT0;
  assign pair   = rel[7:1];
  assign ent_ok = (sel_i >= SEL_ENT0) && (32'(pair) < N_ENT);
  assign idx_o  = pair[IDX_W-1:0];
  assign hi_o   = rel[0];

  always_comb begin
    tgt_o = TGT_NONE;
    if (off_i == OFF_SEL) begin
      tgt_o = TGT_SEL;
    end else if (off_i == OFF_WIN) begin
      case (sel_i)
        SEL_ID:  tgt_o = TGT_ID;
        SEL_VER: tgt_o = TGT_VER;
        SEL_ARB: tgt_o = TGT_ARB;
        default: tgt_o = ent_ok ? TGT_ENT : TGT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ridx_entry_bank.sv
module ridx_entry_bank
  import ridx_pkg::*;
#(
  parameter int unsigned N_ENT = 24,
  parameter int unsigned IDX_W = $clog2(N_ENT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               hi_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rd_half_o,
  output logic [64*N_ENT-1:0] tbl_o
);
  logic [63:0] ent_q [N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[g] <= ENT_RST;
      end else if (wr_i && idx_i == IDX_W'(g)) begin
        if (hi_i) ent_q[g][63:32] <= wdata_i;
        else      ent_q[g][31:0]  <= wdata_i;
      end
    end
    assign tbl_o[64*g +: 64] = ent_q[g];
  end

  logic [63:0] rd_ent;
  always_comb begin
    rd_ent = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (idx_i == IDX_W'(i)) rd_ent = ent_q[i];
    end
  end
  assign rd_half_o = hi_i ? rd_ent[63:32] : rd_ent[31:0];
endmodule

// File: rtl/ridx_window.sv
module ridx_window
  import ridx_pkg::*;
#(
  parameter int unsigned N_ENT = 24,
  parameter int unsigned IDX_W = $clog2(N_ENT)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [7:0]          addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic                rvalid_o,
  output logic [64*N_ENT-1:0] ent_tbl_o,
  output logic                upd_o,
  output logic [IDX_W-1:0]    upd_idx_o
);
  localparam logic [31:0] VER_WORD = {8'h00, 8'(N_ENT - 1), 8'h00, VER_CODE};

  logic [7:0]      sel_q;
  logic [ID_W-1:0] id_q;
  tgt_e            tgt;
  logic [IDX_W-1:0] idx;
  logic            hi;
  logic [31:0]     half_rd;
  logic [31:0]     rd_mux;
  logic            wr, rd, ent_wr;

  assign wr     = req_i && we_i;
  assign rd     = req_i && !we_i;
  assign ent_wr = wr && (tgt == TGT_ENT);

  ridx_decode #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_dec (
    .off_i (addr_i),
    .sel_i (sel_q),
    .tgt_o (tgt),
    .idx_o (idx),
    .hi_o  (hi)
  );

  ridx_entry_bank #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (ent_wr),
    .idx_i     (idx),
    .hi_i      (hi),
    .wdata_i   (wdata_i),
    .rd_half_o (half_rd),
    .tbl_o     (ent_tbl_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      id_q  <= '0;
    end else if (wr) begin
      if (tgt == TGT_SEL) sel_q <= wdata_i[7:0];
      if (tgt == TGT_ID)  id_q  <= wdata_i[ID_LSB +: ID_W];
    end
  end

  always_comb begin
    case (tgt)
      TGT_SEL: rd_mux = {24'h0, sel_q};
      TGT_ID:  rd_mux = 32'(id_q) << ID_LSB;
      TGT_VER: rd_mux = VER_WORD;
      TGT_ENT: rd_mux = half_rd;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o   <= '0;
      rvalid_o  <= 1'b0;
      upd_o     <= 1'b0;
      upd_idx_o <= '0;
    end else begin
      rvalid_o <= rd;
      rdata_o  <= rd ? rd_mux : '0;
      upd_o    <= ent_wr;
      if (ent_wr) upd_idx_o <= idx;
    end
  end
endmodule

// File: rtl/ridx_window_chk.sv
module ridx_window_chk #(
  parameter int unsigned N_ENT = 24,
  parameter int unsigned IDX_W = $clog2(N_ENT)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [7:0]          addr_i,
  input logic [31:0]         rdata_o,
  input logic                rvalid_o,
  input logic [64*N_ENT-1:0] ent_tbl_o,
  input logic                upd_o,
  input logic [IDX_W-1:0]    upd_idx_o,
  input logic [7:0]          sel_q
);
  assert_rvalid_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
  assert_rvalid_only_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);
  assert_rdata_idle_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> rdata_o == '0);
  assert_upd_needs_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && addr_i == 8'h10) |=> !upd_o);
  assert_upd_idx_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> 32'(upd_idx_o) < N_ENT);
  assert_tbl_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(ent_tbl_o));
  assert_sel_stable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && addr_i == 8'h00) |=> $stable(sel_q));
endmodule

bind ridx_window ridx_window_chk #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .rvalid_o  (rvalid_o),
  .ent_tbl_o (ent_tbl_o),
  .upd_o     (upd_o),
  .upd_idx_o (upd_idx_o),
  .sel_q     (sel_q)
);

// File: tb/sim_ridx_window.sv
`timescale 1ns/1ps
module sim_ridx_window;
  localparam int N = 24;
  localparam int IW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rvalid, upd;
  logic [64*N-1:0] tbl;
  logic [IW-1:0] upd_idx;

  always #2.5 clk = ~clk;

  ridx_window #(.N_ENT(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .ent_tbl_o(tbl),
    .upd_o(upd), .upd_idx_o(upd_idx)
  );

  // reference state
  logic [63:0] m_ent [N];
  logic [7:0]  m_sel;
  logic [3:0]  m_id;
  // pending expectations for the next sample
  logic        e_rv = 0, e_upd = 0;
  logic [31:0] e_rd = 0;
  int          e_idx = 0;
  string       e_tag = "R9";
  string       force_tag = "";
  int checks = 0, errors = 0;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("R9", "rvalid", rvalid, e_rv);
    chk(e_rv ? e_tag : "R9", "rdata", rdata, e_rv ? e_rd : 0);
    chk("R10", "upd", upd, e_upd);
    if (e_upd) chk("R10", "upd_idx", upd_idx, e_idx);
    for (int i = 0; i < N; i++) chk("R11", "entry", tbl[64*i +: 64], m_ent[i]);
  endtask

  task automatic step(bit rq, bit w, logic [7:0] a, logic [31:0] d);
    logic [31:0] r;
    string t;
    int k;
    @(negedge clk);
    compare();
    req = rq; we = w; addr = a; wdata = d;
    r = 0; t = "R8"; e_upd = 0;
    if (a == 8'h00) begin
      t = "R1"; r = {24'h0, m_sel};
      if (rq && w) m_sel = d[7:0];
    end else if (a == 8'h10) begin
      if (m_sel == 0) begin
        t = "R2"; r = {4'h0, m_id, 24'h0};
        if (rq && w) m_id = d[27:24];
      end else if (m_sel == 1) begin
        t = "R3"; r = 32'h11 | ((N - 1) << 16);
      end else if (m_sel == 2) begin
        t = "R4"; r = 0;
      end else begin
        k = (int'(m_sel) - 16) / 2;
        if (m_sel >= 16 && k < N) begin
          t = "R5";
          r = m_sel[0] ? m_ent[k][63:32] : m_ent[k][31:0];
          if (rq && w) begin
            if (m_sel[0]) m_ent[k][63:32] = d; else m_ent[k][31:0] = d;
            e_upd = 1; e_idx = k;
          end
        end else t = "R6";
      end
    end
    e_rv = rq && !w;
    e_rd = r;
    e_tag = (force_tag != "") ? force_tag : t;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d); step(1, 1, a, d); endtask
  task automatic rd(logic [7:0] a);                 step(1, 0, a, 0); endtask
  task automatic idle();                            step(0, 0, 0, 0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) m_ent[i] = 64'h1_0000; // R7 reset value
    m_sel = 0; m_id = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R7 / R1 / R2 reset state
    force_tag = "R7";
    rd(8'h00); rd(8'h10);
    wr(8'h00, 8'h10); rd(8'h10); wr(8'h00, 8'h11); rd(8'h10);
    wr(8'h00, 8'h3E); rd(8'h10); wr(8'h00, 8'h3F); rd(8'h10);
    force_tag = "";
    // R1 select register
    wr(8'h00, 32'hFFFF_FFA5); rd(8'h00);
    // R2 ID keeps bits 27:24 only
    wr(8'h00, 0); wr(8'h10, 32'hFFFF_FFFF); rd(8'h10);
    wr(8'h10, 32'h0500_0000); rd(8'h10);
    // R3 version, write ignored
    wr(8'h00, 1); rd(8'h10); wr(8'h10, 32'hFFFF_FFFF); rd(8'h10);
    // R4 arbitration
    wr(8'h00, 2); wr(8'h10, 32'hFFFF_FFFF); rd(8'h10);
    // R5 halves, other half kept; write then read back-to-back (R10 same cycle)
    wr(8'h00, 8'h10); wr(8'h10, 32'hDEAD_BEEF); rd(8'h10);
    wr(8'h00, 8'h11); wr(8'h10, 32'h1234_5678); rd(8'h10);
    wr(8'h00, 8'h10); rd(8'h10);
    wr(8'h00, 8'h3F); wr(8'h10, 32'hCAFE_0001); rd(8'h10);
    wr(8'h00, 8'h2A); wr(8'h10, 32'h0000_00FF); idle(); rd(8'h10);
    // R6 out of range and reserved selects
    wr(8'h00, 8'h40); wr(8'h10, 32'hFFFF_FFFF); rd(8'h10);
    wr(8'h00, 8'hFF); wr(8'h10, 32'hFFFF_FFFF); rd(8'h10);
    wr(8'h00, 8'h05); wr(8'h10, 32'hFFFF_FFFF); rd(8'h10);
    // R8 other offsets
    wr(8'h00, 8'h12);
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04);
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14);
    wr(8'hFF, 32'hFFFF_FFFF); rd(8'hFF); rd(8'h00);
    // mixed stream
    for (int n = 0; n < 2000; n++) begin
      int p;
      logic [7:0] a;
      p = $urandom_range(0, 9);
      a = (p < 3) ? 8'h00 : (p < 9) ? 8'h10 : 8'($urandom);
      if (a == 8'h00 && $urandom_range(0, 1) == 1)
        step(1, 1, a, {24'($urandom), 8'($urandom_range(0, 8'h45))});
      else
        step($urandom_range(0, 4) != 0, $urandom_range(0, 1) == 1, a, $urandom);
    end
    idle(); idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule